// File: doc/BRIEF.md
# Line Transceiver Maintenance Command Controller

This block is the host-side logic on the per-frame control/status exchange of a line transceiver. Each frame the transceiver delivers one status octet. The block keeps a control octet on its output, and the serializer samples it once per frame. The block has three duties:

- It watches the far-end deactivate bit and answers a confirmed deactivation by requesting deactivation itself and quieting every other control bit.
- On command it runs a three-step local loopback sequence: reset, then loopback asserted, then reset with loopback removed. Each step is held for a parameterized number of status frames.
- It sends a test bit as 0 and checks its echo, which exposes a status line stuck at one.

Status frames enter on a valid/ready handshake. `stat_ready` is always high, so the block never applies back-pressure. A frame is consumed on every clock edge where `stat_valid` is high, and cycles without `stat_valid` are not frames. Loopback start and stop commands, the control octet and the two flags are plain level or pulse pins.

Top module: `maint_ctrl`

## Requirements
- R1: Status bit 0 is the far-end deactivate bit. When it is received as 0 in 3 consecutive accepted frames, `deact_seen` and control bit 0 go to 1 on the clock edge that accepts the third such frame.
- R2: An accepted frame with status bit 0 at 1 restarts the zero count, so two zeros, a one and two zeros do not raise `deact_seen`.
- R3: Once deactivation is seen, the control octet is held at 0x05 until reset: bit 0 (deactivate) is 1, bit 1 (stop) is 0, bit 2 (loopback, active low) is 1, bit 3 (reset) is 0 and bit 4 (test) is 0. Loopback start commands have no effect in this condition.
- R4: A `lb_start` pulse while idle enters step 1 on the next edge. Step 1 drives reset=1, stop=1 and loopback=1 (inactive), which gives control octet 0x0E.
- R5: After STEP_FRAMES accepted frames in step 1, the block enters step 2. Step 2 drives reset=0, loopback=0 (active) and stop=1, which gives control octet 0x02.
- R6: After STEP_FRAMES frames in step 2, the block enters step 3 (0x0E). After STEP_FRAMES frames in step 3, it returns to idle (0x04).
- R7: A `lb_stop` pulse during step 1 or step 2 jumps to step 3 with a fresh frame count.
- R8: Status bit 1 is the echo of the test bit, which is always sent as 0 in control bit 4. When the echo reads 1 in 2 consecutive accepted frames, `stuck_fault` rises on the second frame's edge and stays set until reset.
- R9: An accepted frame with the echo at 0 restarts the stuck count.
- R10: After reset the control octet is 0x04, both flags are 0 and `stat_ready` is 1. Control bits 7 to 5 are always 0.
- R11: Clock cycles without `stat_valid` do not count toward any frame count.
- R12: If a frame both completes the deactivation run and ends a loopback step, deactivation takes precedence: the block goes to idle with the octet at 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_valid | input | 1 | A status octet is presented |
| stat_ready | output | 1 | Always 1; the block never stalls |
| stat_octet | input | 8 | Status octet: bit 0 far-end deactivate, bit 1 test echo |
| lb_start | input | 1 | Pulse that starts the loopback sequence |
| lb_stop | input | 1 | Pulse that jumps to the final reset step |
| ctl_octet | output | 8 | Control octet: bit 0 deactivate, 1 stop, 2 loopback (low active), 3 reset, 4 test |
| deact_seen | output | 1 | Far-end deactivation confirmed (sticky) |
| stuck_fault | output | 1 | Echoed test bit stuck at one (sticky) |

## Verification
Deactivation recognition and loopback step advance can land on the same status frame. The bench starts a loopback and then sends three zero-deactivate frames, so the third frame both completes the run and ends step 1. It then expects idle outputs with the deactivate bit set (0x05), not the step-2 pattern. A later start command must leave that octet unchanged.

// File: rtl/maint_ctrl_pkg.sv
package maint_ctrl_pkg;
  typedef enum logic [1:0] {
    LB_IDLE = 2'd0,
    LB_RST1 = 2'd1,
    LB_LOOP = 2'd2,
    LB_RST2 = 2'd3
  } lb_step_t;

  localparam int ST_DEACT = 0;
  localparam int ST_ECHO  = 1;

  localparam int CT_DEACT = 0;
  localparam int CT_STOP  = 1;
  localparam int CT_LOOPN = 2;
  localparam int CT_RST   = 3;
  localparam int CT_TEST  = 4;
endpackage

// File: rtl/deact_det.sv
module deact_det #(
  parameter int RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame,
  input  logic far_deact,
  output logic hit,
  output logic seen
);
  localparam int CW = $clog2(RUN + 1);
  logic [CW-1:0] zrun;

  assign hit = frame && !far_deact && (zrun == CW'(RUN - 1)) && !seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun <= '0;
      seen <= 1'b0;
    end else if (frame) begin
      if (far_deact) zrun <= '0;
      else if (zrun != CW'(RUN)) zrun <= zrun + 1'b1;
      if (hit) seen <= 1'b1;
    end
  end

  AST_SEEN_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seen) |-> $past(frame && !far_deact)); // R1
  AST_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && far_deact) |=> (zrun == '0)); // R2
endmodule

// File: rtl/lb_seq.sv
module lb_seq
  import maint_ctrl_pkg::*;
#(
  parameter int STEP_FRAMES = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     frame,
  input  logic     start,
  input  logic     stop,
  input  logic     abort,
  output lb_step_t step
);
  localparam int SW = $clog2(STEP_FRAMES + 1);
  logic [SW-1:0] cnt;
  logic          last;

  assign last = frame && (cnt == SW'(STEP_FRAMES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= LB_IDLE;
      cnt  <= '0;
    end else if (abort) begin
      step <= LB_IDLE;
      cnt  <= '0;
    end else begin
      unique case (step)
        LB_IDLE: if (start) begin
          step <= LB_RST1;
          cnt  <= '0;
        end
        LB_RST1, LB_LOOP: begin
          if (stop) begin
            step <= LB_RST2;
            cnt  <= '0;
          end else if (last) begin
            step <= (step == LB_RST1) ? LB_LOOP : LB_RST2;
            cnt  <= '0;
          end else if (frame) cnt <= cnt + 1'b1;
        end
        LB_RST2: begin
          if (last) begin
            step <= LB_IDLE;
            cnt  <= '0;
          end else if (frame) cnt <= cnt + 1'b1;
        end
        default: step <= LB_IDLE;
      endcase
    end
  end

  AST_LOOP_AFTER_RST1: assert property (@(posedge clk) disable iff (!rst_n)
    (step == LB_LOOP && $past(step) != LB_LOOP) |-> $past(step) == LB_RST1); // R5
  AST_RST2_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step) == LB_RST2 && step != LB_RST2) |-> step == LB_IDLE); // R6
  AST_NO_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame && !start && !stop && !abort) |=> $stable(step)); // R11
endmodule

// File: rtl/stuck_chk.sv
module stuck_chk #(
  parameter int RUN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame,
  input  logic sent,
  input  logic echo,
  output logic fault
);
  localparam int CW = $clog2(RUN + 1);
  logic [CW-1:0] erun;
  logic          bad;

  assign bad = echo && !sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erun  <= '0;
      fault <= 1'b0;
    end else if (frame) begin
      if (!bad) erun <= '0;
      else if (erun != CW'(RUN)) erun <= erun + 1'b1;
      if (bad && erun == CW'(RUN - 1)) fault <= 1'b1;
    end
  end

  AST_FAULT_NEEDS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(frame && echo)); // R8
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault); // R8
endmodule

// File: rtl/maint_ctrl.sv
module maint_ctrl
  import maint_ctrl_pkg::*;
#(
  parameter int STEP_FRAMES = 3,
  parameter int DEACT_RUN   = 3,
  parameter int STUCK_RUN   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stat_valid,
  output logic       stat_ready,
  input  logic [7:0] stat_octet,
  input  logic       lb_start,
  input  logic       lb_stop,
  output logic [7:0] ctl_octet,
  output logic       deact_seen,
  output logic       stuck_fault
);
  lb_step_t step;
  logic     frame, deact_hit;
  logic     stat_unused;

  assign stat_ready  = 1'b1;
  assign frame       = stat_valid && stat_ready;
  assign stat_unused = ^stat_octet[7:2];

  deact_det #(.RUN(DEACT_RUN)) u_deact (
    .clk(clk), .rst_n(rst_n), .frame(frame),
    .far_deact(stat_octet[ST_DEACT]), .hit(deact_hit), .seen(deact_seen)
  );

  lb_seq #(.STEP_FRAMES(STEP_FRAMES)) u_lb (
    .clk(clk), .rst_n(rst_n), .frame(frame), .start(lb_start),
    .stop(lb_stop), .abort(deact_hit || deact_seen), .step(step)
  );

  always_comb begin
    ctl_octet           = 8'h00;
    ctl_octet[CT_LOOPN] = 1'b1;
    ctl_octet[CT_DEACT] = deact_seen;
    ctl_octet[CT_TEST]  = 1'b0;
    unique case (step)
      LB_RST1, LB_RST2: begin
        ctl_octet[CT_RST]  = 1'b1;
        ctl_octet[CT_STOP] = 1'b1;
      end
      LB_LOOP: begin
        ctl_octet[CT_STOP]  = 1'b1;
        ctl_octet[CT_LOOPN] = 1'b0;
      end
      default: ;
    endcase
  end

  stuck_chk #(.RUN(STUCK_RUN)) u_stuck (
    .clk(clk), .rst_n(rst_n), .frame(frame),
    .sent(ctl_octet[CT_TEST]), .echo(stat_octet[ST_ECHO]), .fault(stuck_fault)
  );

  AST_DEACT_QUIETS_LB: assert property (@(posedge clk) disable iff (!rst_n)
    deact_seen |-> (step == LB_IDLE)); // R3
  AST_DEACT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    deact_seen |=> deact_seen); // R3
  AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    deact_hit |=> (step == LB_IDLE && deact_seen)); // R12
endmodule

// File: tb/maint_ctrl_tb_top.sv
module maint_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stat_valid = 1'b0;
  logic       stat_ready;
  logic [7:0] stat_octet = 8'h01;
  logic       lb_start = 1'b0;
  logic       lb_stop = 1'b0;
  logic [7:0] ctl_octet;
  logic       deact_seen, stuck_fault;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  maint_ctrl #(.STEP_FRAMES(3), .DEACT_RUN(3), .STUCK_RUN(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .stat_valid(stat_valid), .stat_ready(stat_ready),
    .stat_octet(stat_octet), .lb_start(lb_start), .lb_stop(lb_stop),
    .ctl_octet(ctl_octet), .deact_seen(deact_seen), .stuck_fault(stuck_fault)
  );

  // {far deactivate bit, echo bit, expected deact_seen, expected stuck_fault}
  localparam logic [3:0] VEC [8] = '{
    4'b1100, 4'b1000, 4'b0100, 4'b0000,
    4'b1100, 4'b0101, 4'b0001, 4'b0011
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    stat_valid = 1'b0;
    lb_start = 1'b0;
    lb_stop = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic frame(input logic d, input logic e);
    @(negedge clk);
    stat_octet = {6'b0, e, d};
    stat_valid = 1'b1;
    @(negedge clk);
    stat_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    lb_start = 1'b1;
    @(negedge clk);
    lb_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk);
    lb_stop = 1'b1;
    @(negedge clk);
    lb_stop = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    check("R10 ctl", ctl_octet, 8'h04);
    check("R10 flags", {6'b0, deact_seen, stuck_fault}, 8'h00);
    check("R10 ready", {7'b0, stat_ready}, 8'h01);

    // R1 R2 R8 R9 vector walk
    for (int i = 0; i < 8; i++) begin
      frame(VEC[i][3], VEC[i][2]);
      check("R1/R2 deact_seen", {7'b0, deact_seen}, {7'b0, VEC[i][1]});
      check("R8/R9 stuck_fault", {7'b0, stuck_fault}, {7'b0, VEC[i][0]});
    end
    check("R3 ctl after deact", ctl_octet, 8'h05);
    pulse_start();
    check("R3 start ignored", ctl_octet, 8'h05);
    frame(1'b1, 1'b0);
    check("R3 sticky", {7'b0, deact_seen}, 8'h01);

    // loopback full sequence
    do_reset();
    pulse_start();
    check("R4 step1", ctl_octet, 8'h0E);
    frame(1'b1, 1'b0);
    frame(1'b1, 1'b0);
    check("R5 step1 held", ctl_octet, 8'h0E);
    frame(1'b1, 1'b0);
    check("R5 step2", ctl_octet, 8'h02);
    repeat (6) @(negedge clk);
    check("R11 idle cycles", ctl_octet, 8'h02);
    frame(1'b1, 1'b0);
    frame(1'b1, 1'b0);
    frame(1'b1, 1'b0);
    check("R6 step3", ctl_octet, 8'h0E);
    frame(1'b1, 1'b0);
    frame(1'b1, 1'b0);
    check("R6 step3 held", ctl_octet, 8'h0E);
    frame(1'b1, 1'b0);
    check("R6 idle", ctl_octet, 8'h04);

    // R7 stop in step 2
    pulse_start();
    frame(1'b1, 1'b0);
    frame(1'b1, 1'b0);
    frame(1'b1, 1'b0);
    check("R7 in step2", ctl_octet, 8'h02);
    pulse_stop();
    check("R7 jump step3", ctl_octet, 8'h0E);
    frame(1'b1, 1'b0);
    frame(1'b1, 1'b0);
    check("R7 fresh count", ctl_octet, 8'h0E);
    frame(1'b1, 1'b0);
    check("R7 back idle", ctl_octet, 8'h04);

    // R12 precedence on the same frame
    do_reset();
    pulse_start();
    frame(1'b0, 1'b0);
    frame(1'b0, 1'b0);
    check("R12 before", ctl_octet, 8'h0E);
    frame(1'b0, 1'b0);
    check("R12 deact wins", ctl_octet, 8'h05);
    check("R12 seen", {7'b0, deact_seen}, 8'h01);
    pulse_start();
    check("R12 R3 restart ignored", ctl_octet, 8'h05);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule